// File: doc/BRIEF.md
# Shared Core Throttle and Stop-Clock Controller

This block decides, every cycle, whether a single physical core that carries two hardware threads may be clocked. It combines three sources of slowdown. The first is a temperature comparison against two programmable limits. The second is a pair of per-thread software throttle settings. The third is an external active-low stop-clock pin. It then drives one clock-enable for the core and a set of state flags that apply to both threads together.

Software throttling gives each thread its own enable bit and its own 3-bit on-time setting. The core runs at the larger of the enabled settings. Crossing the lower temperature limit forces a fixed half-rate gate, and the lower of the two on-times wins. Crossing the upper limit shuts the core down until reset. Pulling the stop-clock pin low parks the core in a stop-grant state. In that state execution and interrupt acceptance stop for both threads, but snoops are still served.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: While reset is held, clk_en_o, halt_o, stop_grant_o and irq_block_o are 0 and snoop_ok_o is 1.
- R2: When no software throttle is active and temp_i is not above trip_thr_i, clk_en_o is 1 in every cycle.
- R3: A thread whose enable bit is 1 and whose 3-bit setting N (bits [3t+2:3t] of sw_duty_i for thread t) is 1 to 7 makes clk_en_o high in exactly N of any 8 consecutive cycles. A setting of 0, or an enable of 0, leaves that thread without effect.
- R4: When both threads request throttling, the on-time is the larger of the two settings.
- R5: temp_i strictly greater than trip_thr_i gates the clock to 4 of 8 cycles. Equality has no effect.
- R6: When thermal and software throttling are both active, the smaller on-time applies.
- R7: temp_i strictly greater than cat_thr_i sets halt_o and irq_block_o and clears clk_en_o and snoop_ok_o on the next rising edge. Equality has no effect.
- R8: That shutdown stays in force after the temperature falls, until reset.
- R9: stop_clk_ni low is passed through two synchronizing flops. stop_grant_o, halt_o and irq_block_o rise on the third rising edge after the pin is sampled low, while clk_en_o stays 0 and snoop_ok_o stays 1.
- R10: stop_grant_o falls on the third rising edge after the pin is sampled high. halt_o and irq_block_o fall with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| temp_i | input | TEMP_W | Current core temperature code |
| cat_thr_i | input | TEMP_W | Shutdown limit |
| trip_thr_i | input | TEMP_W | Thermal throttle limit |
| sw_mod_en_i | input | THREADS | Per-thread software throttle enable |
| sw_duty_i | input | THREADS*DUTY_W | Per-thread on-time settings, thread t in bits [DUTY_W*t+DUTY_W-1:DUTY_W*t] |
| stop_clk_ni | input | 1 | Asynchronous active-low stop-clock request |
| clk_en_o | output | 1 | Per-cycle core clock enable |
| halt_o | output | 1 | Both threads halted |
| stop_grant_o | output | 1 | Core is in stop-grant |
| irq_block_o | output | 1 | Interrupts refused by both threads |
| snoop_ok_o | output | 1 | Snoop responses allowed |

## Verification
The bench sweeps every combination of the two enable bits, both 3-bit settings and the thermal trip. For each one it counts enabled cycles over an 8-cycle window. A merge that took the minimum, or that let a disabled thread or a zero setting count, would produce wrong counts. So would a design that let software override the thermal cap. Both limits are driven at exactly the threshold, so a comparison written as greater-or-equal shows up at once. Stop-grant entry and exit are sampled on each edge around the synchronizer. A missing or extra flop shifts the transition by a cycle. After the shutdown temperature is removed, the bench confirms that the halt holds and that only reset clears it.

// File: rtl/thr_pkg.sv
package thr_pkg;

    // Operating mode of the shared core, in priority order
    typedef enum logic [1:0] {
        MODE_RUN      = 2'd0,
        MODE_STOPGNT  = 2'd1,
        MODE_SHUTDOWN = 2'd2
    } core_mode_e;

    function automatic core_mode_e pick_mode(input logic shutdown, input logic stop_gnt);
        if (shutdown)      return MODE_SHUTDOWN;
        else if (stop_gnt) return MODE_STOPGNT;
        else               return MODE_RUN;
    endfunction

endpackage

// File: rtl/thr_sync.sv
module thr_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= {STAGES{RESET_VAL}};
        else         sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/thr_duty_merge.sv
module thr_duty_merge #(
    parameter int THREADS  = 2,
    parameter int DUTY_W   = 3,
    parameter int THERM_ON = 4,
    localparam int PERIOD  = 1 << DUTY_W,
    localparam int EFF_W   = DUTY_W + 1
) (
    input  logic [THREADS-1:0]        sw_en_i,
    input  logic [THREADS*DUTY_W-1:0] sw_duty_i,
    input  logic                      trip_i,
    output logic [EFF_W-1:0]          eff_duty_o
);

    logic [THREADS-1:0][DUTY_W-1:0] cand;

    // A thread contributes only when enabled with a non-zero setting
    for (genvar t = 0; t < THREADS; t++) begin : g_cand
        logic [DUTY_W-1:0] raw;
        assign raw     = sw_duty_i[t*DUTY_W +: DUTY_W];
        assign cand[t] = sw_en_i[t] ? raw : '0;
    end

    logic [DUTY_W-1:0] sw_max;
    logic [EFF_W-1:0]  sw_eff;

    always_comb begin
        sw_max = '0;
        for (int i = 0; i < THREADS; i++) begin
            if (cand[i] > sw_max) sw_max = cand[i];
        end
        sw_eff = (sw_max == '0) ? EFF_W'(PERIOD) : {1'b0, sw_max};
        if (trip_i && (sw_eff > EFF_W'(THERM_ON))) eff_duty_o = EFF_W'(THERM_ON);
        else                                       eff_duty_o = sw_eff;
    end

endmodule

// File: rtl/thr_state_ctrl.sv
module thr_state_ctrl
    import thr_pkg::*;
#(
    parameter int TEMP_W  = 8,
    parameter int DUTY_W  = 3,
    localparam int EFF_W  = DUTY_W + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic [TEMP_W-1:0] cat_thr_i,
    input  logic [TEMP_W-1:0] trip_thr_i,
    input  logic              stop_req_i,
    input  logic [EFF_W-1:0]  eff_duty_i,
    output logic              trip_o,
    output logic              clk_en_o,
    output logic              halt_o,
    output logic              stop_grant_o,
    output logic              irq_block_o,
    output logic              snoop_ok_o
);

    typedef struct packed {
        logic [DUTY_W-1:0] phase;
        logic              cat;
        logic              trip;
        logic              sg;
        logic              clk_en;
    } st_t;

    st_t        st_d, st_q;
    core_mode_e mode;

    always_comb begin
        st_d        = st_q;
        st_d.phase  = st_q.phase + 1'b1;
        st_d.cat    = st_q.cat | (temp_i > cat_thr_i);
        st_d.trip   = (temp_i > trip_thr_i);
        st_d.sg     = stop_req_i;
        st_d.clk_en = !(st_d.cat || st_d.sg) && ({1'b0, st_q.phase} < eff_duty_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        mode         = pick_mode(st_q.cat, st_q.sg);
        halt_o       = (mode != MODE_RUN);
        irq_block_o  = (mode != MODE_RUN);
        snoop_ok_o   = (mode != MODE_SHUTDOWN);
        stop_grant_o = st_q.sg;
        clk_en_o     = st_q.clk_en;
        trip_o       = st_q.trip;
    end

    // R8: shutdown never clears without reset
    a_r8_cat_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cat |=> st_q.cat);
    // R7: shutdown halts and gates the clock
    a_r7_cat_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cat |-> (halt_o && !clk_en_o && !snoop_ok_o));
    // R9: synchronized request enters stop-grant next edge
    a_r9_req_grants: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_req_i |=> stop_grant_o);
    // R10: released request leaves stop-grant next edge
    a_r10_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !stop_req_i |=> !stop_grant_o);
    // R9: snoops stay served in stop-grant
    a_r9_snoop_in_sg: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_grant_o && !st_q.cat) |-> (snoop_ok_o && irq_block_o && !clk_en_o));

endmodule

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl #(
    parameter int TEMP_W   = 8,
    parameter int THREADS  = 2,
    parameter int DUTY_W   = 3,
    parameter int SYNC_N   = 2,
    parameter int THERM_ON = (1 << DUTY_W) / 2
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [TEMP_W-1:0]         temp_i,
    input  logic [TEMP_W-1:0]         cat_thr_i,
    input  logic [TEMP_W-1:0]         trip_thr_i,
    input  logic [THREADS-1:0]        sw_mod_en_i,
    input  logic [THREADS*DUTY_W-1:0] sw_duty_i,
    input  logic                      stop_clk_ni,
    output logic                      clk_en_o,
    output logic                      halt_o,
    output logic                      stop_grant_o,
    output logic                      irq_block_o,
    output logic                      snoop_ok_o
);

    localparam int EFF_W = DUTY_W + 1;

    logic             pin_sync;
    logic             stop_req;
    logic             trip;
    logic [EFF_W-1:0] eff_duty;

    thr_sync #(.STAGES(SYNC_N), .RESET_VAL(1'b1)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (stop_clk_ni),
        .q_o    (pin_sync)
    );

    assign stop_req = !pin_sync;

    thr_duty_merge #(.THREADS(THREADS), .DUTY_W(DUTY_W), .THERM_ON(THERM_ON)) u_merge (
        .sw_en_i    (sw_mod_en_i),
        .sw_duty_i  (sw_duty_i),
        .trip_i     (trip),
        .eff_duty_o (eff_duty)
    );

    thr_state_ctrl #(.TEMP_W(TEMP_W), .DUTY_W(DUTY_W)) u_state (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .temp_i       (temp_i),
        .cat_thr_i    (cat_thr_i),
        .trip_thr_i   (trip_thr_i),
        .stop_req_i   (stop_req),
        .eff_duty_i   (eff_duty),
        .trip_o       (trip),
        .clk_en_o     (clk_en_o),
        .halt_o       (halt_o),
        .stop_grant_o (stop_grant_o),
        .irq_block_o  (irq_block_o),
        .snoop_ok_o   (snoop_ok_o)
    );

    // R6: thermal trip caps the on-time
    a_r6_therm_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trip |-> (eff_duty <= EFF_W'(THERM_ON)));

    // R4: merged on-time never below an active thread's request
    for (genvar t = 0; t < THREADS; t++) begin : g_chk
        a_r4_not_below: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (sw_mod_en_i[t] && (sw_duty_i[t*DUTY_W +: DUTY_W] != '0) && !trip)
            |-> (eff_duty >= {1'b0, sw_duty_i[t*DUTY_W +: DUTY_W]}));
    end

endmodule

// File: tb/thermal_throttle_ctrl_tb_top.sv
module thermal_throttle_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] temp, cat_thr, trip_thr;
    logic [1:0] sw_en;
    logic [5:0] sw_duty;
    logic       stop_n;
    logic       clk_en, halt, sg, irq_blk, snoop_ok;

    int errs   = 0;
    int checks = 0;

    always #10 clk = ~clk;

    thermal_throttle_ctrl dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .temp_i       (temp),
        .cat_thr_i    (cat_thr),
        .trip_thr_i   (trip_thr),
        .sw_mod_en_i  (sw_en),
        .sw_duty_i    (sw_duty),
        .stop_clk_ni  (stop_n),
        .clk_en_o     (clk_en),
        .halt_o       (halt),
        .stop_grant_o (sg),
        .irq_block_o  (irq_blk),
        .snoop_ok_o   (snoop_ok)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic count_en(output int n);
        n = 0;
        repeat (8) begin
            @(negedge clk);
            if (clk_en) n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks + 1);
        $finish;
    end

    initial begin
        int n;
        rst_n    = 1'b0;
        temp     = 8'd0;
        cat_thr  = 8'd120;
        trip_thr = 8'd80;
        sw_en    = 2'b00;
        sw_duty  = 6'd0;
        stop_n   = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 clk_en", clk_en, 0);
        chk("R1 halt", halt, 0);
        chk("R1 stop_grant", sg, 0);
        chk("R1 irq_block", irq_blk, 0);
        chk("R1 snoop_ok", snoop_ok, 1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        count_en(n);
        chk("R2 free run", n, 8);

        // Sweep every enable/setting pair with and without thermal trip
        for (int tr = 0; tr < 2; tr++)
            for (int e0 = 0; e0 < 2; e0++)
                for (int e1 = 0; e1 < 2; e1++)
                    for (int d0 = 0; d0 < 8; d0++)
                        for (int d1 = 0; d1 < 8; d1++) begin
                            int s0, s1, sw, exp_n;
                            string tag;
                            @(negedge clk);
                            temp    = (tr != 0) ? 8'd81 : 8'd80;
                            sw_en   = {e1[0], e0[0]};
                            sw_duty = {d1[2:0], d0[2:0]};
                            s0 = (e0 != 0) ? d0 : 0;
                            s1 = (e1 != 0) ? d1 : 0;
                            sw = (s0 > s1) ? s0 : s1;
                            exp_n = (sw == 0) ? 8 : sw;
                            if (tr != 0 && exp_n > 4) exp_n = 4;
                            if (tr != 0 && sw != 0)      tag = "R6 thermal+sw";
                            else if (tr != 0)            tag = "R5 thermal";
                            else if (s0 != 0 && s1 != 0) tag = "R4 max merge";
                            else if (sw != 0)            tag = "R3 single thread";
                            else                         tag = "R2 inactive (R5 equal temp)";
                            repeat (3) @(negedge clk);
                            count_en(n);
                            chk(tag, n, exp_n);
                        end

        @(negedge clk);
        temp = 8'd0; sw_en = 2'b00;
        repeat (3) @(negedge clk);

        // Stop-clock entry
        stop_n = 1'b0;
        @(negedge clk); chk("R9 sg edge1", sg, 0);
        @(negedge clk); chk("R9 sg edge2", sg, 0);
        @(negedge clk); chk("R9 sg edge3", sg, 1);
        chk("R9 halt", halt, 1);
        chk("R9 irq_block", irq_blk, 1);
        chk("R9 snoop_ok", snoop_ok, 1);
        count_en(n);
        chk("R9 clock gated", n, 0);
        // Stop-clock exit
        stop_n = 1'b1;
        @(negedge clk); chk("R10 sg edge1", sg, 1);
        @(negedge clk); chk("R10 sg edge2", sg, 1);
        @(negedge clk); chk("R10 sg edge3", sg, 0);
        chk("R10 halt", halt, 0);
        chk("R10 irq_block", irq_blk, 0);
        chk("R10 clk_en", clk_en, 1);

        // Shutdown limit
        temp = 8'd120;
        repeat (3) @(negedge clk);
        chk("R7 equal temp", halt, 0);
        temp = 8'd121;
        @(negedge clk);
        chk("R7 halt", halt, 1);
        chk("R7 clk_en", clk_en, 0);
        chk("R7 snoop_ok", snoop_ok, 0);
        chk("R7 irq_block", irq_blk, 1);
        chk("R7 stop_grant", sg, 0);
        temp = 8'd0;
        repeat (6) @(negedge clk);
        chk("R8 still halted", halt, 1);
        count_en(n);
        chk("R8 clock gated", n, 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 reset clears halt", halt, 0);
        chk("R8 reset snoop_ok", snoop_ok, 1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        count_en(n);
        chk("R8 runs after reset", n, 8);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule